// File: doc/BRIEF.md
# Dual-Link Video Receive Pixel Merger

This block sits behind a pair of video link receivers, a master and a slave, and turns their outputs into one stream that carries two pixels, an even one and an odd one, on each pixel clock. In single-link operation the master drives both 24-bit pixel buses. In dual-link operation the master drives only the even pixels and the slave drives the odd pixels. The slave's bus arrives with its bit order flipped, so the block restores it. The master's odd bus is undriven in this mode and the block ignores it.

Data enable, horizontal sync and vertical sync are registered in the same stage as the pixels. The link mode is sampled only between lines, so a change cannot split a line. An optional line buffer, selected at build time, can mirror every line horizontally. A runtime switch, also sampled between lines, turns the mirroring on or off. A mirrored line comes out during the following active line, with the pair order reversed and the two pixels of each pair exchanged.

Top module: `pixel_pair_merge`

## Requirements
- R1: In single-link mode (`linkDual` latched as 0), an active cycle's `mstEven` and `mstOdd` appear on `outEven` and `outOdd` one clock later.
- R2: In dual-link mode (`linkDual` latched as 1), `outOdd` one clock later equals `slvOdd` bit-reversed (output bit i = input bit 23-i). `mstOdd` has no effect, and `outEven` still follows `mstEven`.
- R3: `linkDual` is latched only on clocks where `inDe` is low. A change while `inDe` is high does not alter the line in progress.
- R4: `outDe`, `outHs` and `outVs` equal `inDe`, `inHs` and `inVs` from one clock earlier.
- R5: Whenever `outDe` is low, `outEven` and `outOdd` are zero, whatever the pixel inputs carry.
- R6: With mirroring active, output pair j of a line equals pair L-1-j of the previous line with even and odd exchanged. L is the pair count of the previous line, and the stored odd value is the one selected under R1/R2.
- R7: `mirrorOn` is latched only on clocks where `inDe` is low. A change while `inDe` is high does not alter the line in progress.
- R8: With mirroring active, output pairs at positions j >= L, including every pair when no line has been seen since reset, are zero.
- R9: Only the first MAX_PAIRS (default 32) pairs of a line are stored. L saturates at MAX_PAIRS.
- R10: While `rstN` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (master receiver output clock) |
| rstN | input | 1 | Active-low synchronous reset |
| linkDual | input | 1 | 1 = dual-link, 0 = single-link; latched while `inDe` is low |
| mirrorOn | input | 1 | Runtime mirror switch; latched while `inDe` is low |
| mstEven | input | 24 | Master even-pixel bus |
| mstOdd | input | 24 | Master odd-pixel bus (single-link only) |
| slvOdd | input | 24 | Slave pixel bus, bit-reversed |
| inDe | input | 1 | Data enable from master |
| inHs | input | 1 | Horizontal sync from master |
| inVs | input | 1 | Vertical sync from master |
| outEven | output | 24 | Merged even pixel |
| outOdd | output | 24 | Merged odd pixel |
| outDe | output | 1 | Registered data enable |
| outHs | output | 1 | Registered horizontal sync |
| outVs | output | 1 | Registered vertical sync |

## Verification
The hardest conditions to reach are a mirrored line whose length differs from the line before it, and a line longer than the buffer. Only there do the zero fill and the saturated stored length show at the outputs. The stimulus enables mirroring and then drives lines of 8, 6, 10 and 40 pairs back to back. It follows with a second 40-pair line, so the read-back of a truncated line is seen. Mode and mirror flips are injected in the middle of active lines to show that the latches hold.

// File: rtl/pixmerge_pkg.sv
package pixmerge_pkg;
  // strobes from the control block to the datapath
  typedef struct packed {
    logic wrEn;      // store the current pair in the line buffer
    logic rdValid;   // mirrored read position lies inside the previous line
    logic wrBank;    // buffer half being written; the other half is read
    logic useSlave;  // odd pixel comes from the slave (dual-link)
    logic useMirror; // output comes from the line buffer
  } mergeStrobes_t;
endpackage

// File: rtl/merge_ctrl.sv
module merge_ctrl
  import pixmerge_pkg::*;
#(
  parameter int MAX_PAIRS = 32,
  parameter bit MIRROR_EN = 1'b1,
  localparam int CNT_W  = $clog2(MAX_PAIRS + 1),
  localparam int ADDR_W = $clog2(MAX_PAIRS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inDe,
  input  logic              linkDual,
  input  logic              mirrorOn,
  output mergeStrobes_t     stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr
);
  logic             dualQ, mirQ, deQ, bankQ;
  logic [CNT_W-1:0] pairIdx, prevLen;
  logic             lineEnd;

  assign lineEnd = !inDe && deQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dualQ   <= 1'b0;
      mirQ    <= 1'b0;
      deQ     <= 1'b0;
      bankQ   <= 1'b0;
      pairIdx <= '0;
      prevLen <= '0;
    end else begin
      deQ <= inDe;
      if (!inDe) begin
        dualQ <= linkDual;
        mirQ  <= mirrorOn && MIRROR_EN;
      end
      if (inDe) begin
        if (pairIdx != CNT_W'(MAX_PAIRS)) pairIdx <= pairIdx + CNT_W'(1);
      end else begin
        pairIdx <= '0;
      end
      if (lineEnd) begin
        prevLen <= pairIdx;
        bankQ   <= ~bankQ;
      end
    end
  end

  always_comb begin
    stb.wrEn      = inDe && (pairIdx < CNT_W'(MAX_PAIRS));
    stb.rdValid   = inDe && (pairIdx < prevLen);
    stb.wrBank    = bankQ;
    stb.useSlave  = dualQ;
    stb.useMirror = mirQ;
    wrAddr        = pairIdx[ADDR_W-1:0];
    rdAddr        = prevLen[ADDR_W-1:0] - pairIdx[ADDR_W-1:0] - ADDR_W'(1);
  end

  // R3
  modeHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inDe && $past(inDe)) |-> $stable(stb.useSlave));
  // R7
  mirrorHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inDe && $past(inDe)) |-> $stable(stb.useMirror));
  // R9
  storedLen_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(prevLen) <= MAX_PAIRS);
  // R6
  rdRange_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdValid |-> (int'(rdAddr) < int'(prevLen)));
  // R6
  bankFlip_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineEnd |=> (stb.wrBank != $past(stb.wrBank)));
endmodule

// File: rtl/merge_dp.sv
module merge_dp
  import pixmerge_pkg::*;
#(
  parameter int PIX_W     = 24,
  parameter int MAX_PAIRS = 32,
  parameter bit MIRROR_EN = 1'b1,
  localparam int ADDR_W   = $clog2(MAX_PAIRS),
  localparam int WORD_W   = 2 * PIX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  mergeStrobes_t     stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [PIX_W-1:0]  mstEven,
  input  logic [PIX_W-1:0]  mstOdd,
  input  logic [PIX_W-1:0]  slvOdd,
  input  logic              inDe,
  input  logic              inHs,
  input  logic              inVs,
  output logic [PIX_W-1:0]  outEven,
  output logic [PIX_W-1:0]  outOdd,
  output logic              outDe,
  output logic              outHs,
  output logic              outVs
);
  logic [PIX_W-1:0]  slvFix, oddSel;
  logic [WORD_W-1:0] rdWord;

  always_comb begin
    for (int i = 0; i < PIX_W; i++) slvFix[i] = slvOdd[PIX_W-1-i];
    oddSel = stb.useSlave ? slvFix : mstOdd;
  end

  generate
    if (MIRROR_EN) begin : g_lineBuf
      logic [WORD_W-1:0] lineMem [2][MAX_PAIRS];
      always_ff @(posedge clk) begin
        if (stb.wrEn) lineMem[stb.wrBank][wrAddr] <= {oddSel, mstEven};
      end
      assign rdWord = stb.rdValid ? lineMem[~stb.wrBank][rdAddr] : '0;
    end else begin : g_noBuf
      assign rdWord = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outEven <= '0;
      outOdd  <= '0;
      outDe   <= 1'b0;
      outHs   <= 1'b0;
      outVs   <= 1'b0;
    end else begin
      outDe <= inDe;
      outHs <= inHs;
      outVs <= inVs;
      if (!inDe) begin
        outEven <= '0;
        outOdd  <= '0;
      end else if (stb.useMirror) begin
        outEven <= rdWord[WORD_W-1:PIX_W];
        outOdd  <= rdWord[PIX_W-1:0];
      end else begin
        outEven <= mstEven;
        outOdd  <= oddSel;
      end
    end
  end

  // R4
  deDelay_chk: assert property (@(posedge clk) disable iff (!rstN)
    outDe == $past(inDe));
  // R4
  syncDelay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outHs == $past(inHs)) && (outVs == $past(inVs)));
  // R5
  blankZero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outDe |-> (outEven == '0 && outOdd == '0));
  // R2
  slaveOrder_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inDe) && $past(stb.useSlave) && !$past(stb.useMirror))
      |-> (outOdd[0] == $past(slvOdd[PIX_W-1])));
endmodule

// File: rtl/pixel_pair_merge.sv
module pixel_pair_merge #(
  parameter int PIX_W     = 24,
  parameter int MAX_PAIRS = 32,
  parameter bit MIRROR_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             linkDual,
  input  logic             mirrorOn,
  input  logic [PIX_W-1:0] mstEven,
  input  logic [PIX_W-1:0] mstOdd,
  input  logic [PIX_W-1:0] slvOdd,
  input  logic             inDe,
  input  logic             inHs,
  input  logic             inVs,
  output logic [PIX_W-1:0] outEven,
  output logic [PIX_W-1:0] outOdd,
  output logic             outDe,
  output logic             outHs,
  output logic             outVs
);
  import pixmerge_pkg::*;
  localparam int ADDR_W = $clog2(MAX_PAIRS);

  mergeStrobes_t     stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  merge_ctrl #(.MAX_PAIRS(MAX_PAIRS), .MIRROR_EN(MIRROR_EN)) u_ctrl (
    .clk(clk), .rstN(rstN), .inDe(inDe), .linkDual(linkDual),
    .mirrorOn(mirrorOn), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  merge_dp #(.PIX_W(PIX_W), .MAX_PAIRS(MAX_PAIRS), .MIRROR_EN(MIRROR_EN)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .mstEven(mstEven), .mstOdd(mstOdd), .slvOdd(slvOdd),
    .inDe(inDe), .inHs(inHs), .inVs(inVs),
    .outEven(outEven), .outOdd(outOdd),
    .outDe(outDe), .outHs(outHs), .outVs(outVs)
  );
endmodule

// File: tb/pixel_pair_merge_tb.sv
module pixel_pair_merge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PW   = 24;
  localparam int MAXP = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic linkDual = 1'b0, mirrorOn = 1'b0;
  logic [PW-1:0] mstEven = '0, mstOdd = '0, slvOdd = '0;
  logic inDe = 1'b0, inHs = 1'b0, inVs = 1'b0;
  logic [PW-1:0] outEven, outOdd;
  logic outDe, outHs, outVs;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_pair_merge u_dut (
    .clk(clk), .rstN(rstN), .linkDual(linkDual), .mirrorOn(mirrorOn),
    .mstEven(mstEven), .mstOdd(mstOdd), .slvOdd(slvOdd),
    .inDe(inDe), .inHs(inHs), .inVs(inVs),
    .outEven(outEven), .outOdd(outOdd),
    .outDe(outDe), .outHs(outHs), .outVs(outVs)
  );

  typedef struct {
    bit de, hs, vs;
    logic [PW-1:0] ev, od;
    string tag;
  } exp_t;
  exp_t expQ[$];

  int checks = 0, fails = 0;
  bit mDual = 0, mMir = 0, inLine = 0;
  int prevCnt = 0, curCnt = 0;
  logic [PW-1:0] prevEv[MAXP], prevOd[MAXP], curEv[MAXP], curOd[MAXP];

  function automatic logic [PW-1:0] rev(logic [PW-1:0] v);
    logic [PW-1:0] r;
    for (int i = 0; i < PW; i++) r[i] = v[PW-1-i];
    return r;
  endfunction

  task automatic check(string tag, string what, logic [PW-1:0] act, logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic idle(int n, bit dual, bit mir);
    if (inLine) begin
      prevCnt = (curCnt > MAXP) ? MAXP : curCnt;
      for (int k = 0; k < MAXP; k++) begin prevEv[k] = curEv[k]; prevOd[k] = curOd[k]; end
      inLine = 0;
    end
    for (int i = 0; i < n; i++) begin
      exp_t e;
      @(negedge clk);
      inDe = 0; inHs = (i == 0); inVs = (i == 1);
      linkDual = dual; mirrorOn = mir;
      mstEven = PW'($urandom); mstOdd = PW'($urandom); slvOdd = PW'($urandom);
      e.de = 0; e.hs = inHs; e.vs = inVs; e.ev = '0; e.od = '0; e.tag = "R5";
      expQ.push_back(e);
    end
    mDual = dual; mMir = mir;
  endtask

  task automatic line(int n, int seed, int flipAt, int flipMirAt);
    inLine = 1; curCnt = 0;
    for (int j = 0; j < n; j++) begin
      exp_t e;
      logic [PW-1:0] ev, od, sl, sel;
      @(negedge clk);
      ev = PW'(seed * 4099 + j * 131 + 5);
      od = PW'(seed * 733 + j * 977 + 11);
      sl = PW'(seed * 2311 + j * 57 + 3) ^ 24'hA50F3C;
      inDe = 1; inHs = 0; inVs = 0;
      mstEven = ev; mstOdd = od; slvOdd = sl;
      if (j == flipAt) linkDual = ~linkDual;
      if (j == flipMirAt) mirrorOn = ~mirrorOn;
      sel = mDual ? rev(sl) : od;
      if (j < MAXP) begin curEv[j] = ev; curOd[j] = sel; end
      curCnt++;
      e.de = 1; e.hs = 0; e.vs = 0;
      if (mMir) begin
        if (j < prevCnt) begin
          e.ev = prevOd[prevCnt-1-j]; e.od = prevEv[prevCnt-1-j]; e.tag = "R6";
        end else begin
          e.ev = '0; e.od = '0; e.tag = "R8";
        end
      end else begin
        e.ev = ev; e.od = sel; e.tag = mDual ? "R2" : "R1";
      end
      if (flipAt >= 0) e.tag = "R3";
      if (flipMirAt >= 0) e.tag = "R7";
      if (n > MAXP && e.tag != "R8") e.tag = "R9";
      expQ.push_back(e);
    end
  endtask

  // monitor: pops one expected item per clock and compares
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check("R4", "de/hs/vs", PW'({outDe, outHs, outVs}), PW'({e.de, e.hs, e.vs}));
        check(e.tag, "even", outEven, e.ev);
        check(e.tag, "odd", outOdd, e.od);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL R4 watchdog: actual running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "even", outEven, '0);
    check("R10", "odd", outOdd, '0);
    check("R10", "de/hs/vs", PW'({outDe, outHs, outVs}), '0);
    rstN = 1;
    idle(4, 0, 0); line(8, 1, -1, -1);   // R1
    idle(4, 1, 0); line(8, 2, -1, -1);   // R2
    idle(3, 1, 0); line(8, 3, 3, -1);    // R3 mid-line mode flip
    idle(3, 0, 0); line(8, 4, -1, -1);   // R1 again after flip
    idle(3, 0, 1); line(6, 5, -1, -1);   // R6 mirror of 8-pair line
    idle(3, 0, 1); line(10, 6, -1, -1);  // R8 beyond previous length
    idle(3, 1, 1); line(10, 7, -1, 4);   // R7 mid-line mirror flip, dual stored
    idle(3, 0, 1); line(40, 8, -1, -1);  // R9 overlong line stored
    idle(3, 0, 1); line(40, 9, -1, -1);  // R9 read back, R8 tail
    idle(3, 0, 0); line(5, 10, -1, -1);  // R1 mirror off
    idle(4, 0, 0);
    repeat (3) @(posedge clk);
    #2;
    summary();
  end
endmodule